// File: doc/BRIEF.md
# UART Line Status and Receive FIFO

This block sits between a UART receive engine, a transmit shifter and a register bus. Each character from the receiver arrives with three error flags: parity, framing and break. The block stores the character and its flags together in a receive FIFO. It also presents an 8-bit line status word. Software polls that word, pops characters through the receive buffer port, and reads the status to acknowledge errors.

The error bits in the status word describe the character now at the head of the FIFO, not the last character received. A summary bit tells software that some character still in the FIFO carries an error. That bit survives status reads until no errored character is left. When the FIFO is disabled, the buffer holds one character and error bits appear as soon as that character is received. The block also reports whether the transmit holding register is empty, and whether the whole transmitter (holding register and shift register) is empty.

Top module: `uart_lsr_rxq`

## Requirements
- R1: Status bit 0 (data ready) is 1 exactly while the receive buffer holds a character. `rbr_data` shows the oldest character and reads 0 when the buffer is empty. Characters leave in arrival order, and one `rbr_rd` pulse removes one character.
- R2: The buffer holds DEPTH characters when `fifo_en` is 1 and one character when `fifo_en` is 0. A character offered while the buffer is full, with no pop in the same cycle, is dropped. In the next cycle it sets status bit 1 (overrun).
- R3: `rx_err` has parity in bit 0, framing in bit 1 and break in bit 2. Status bits 2, 3 and 4 show these flags for the character at the buffer head. They appear in the same cycle as that character appears on `rbr_data`.
- R4: A `stat_rd` pulse clears status bits 1 to 4 in the next cycle. It does not remove any character.
- R5: An overrun, or a new head character carrying an error, in the same cycle as `stat_rd` leaves the corresponding bit set.
- R6: With `fifo_en` = 1, accepting a character that has any error flag sets status bit 7 in the next cycle.
- R7: A `stat_rd` clears status bit 7 only if no errored character remains in the buffer after that cycle. Status bit 7 is held at 0 while `fifo_en` is 0.
- R8: Status bit 5 (holding register empty) is 1 after reset. It is 0 in the cycle after `thr_wr`. It returns to 1 in the cycle after `tx_load` if no `thr_wr` occurs in that cycle.
- R9: Status bit 6 (transmitter empty) is 1 exactly when status bit 5 is 1 and `tx_busy` is 0. It is 1 after reset.
- R10: Any change of `fifo_en` empties the receive buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = DEPTH-entry FIFO mode, 0 = single-character mode |
| rx_valid | input | 1 | Receive engine offers a character this cycle |
| rx_data | input | DATA_W | Received character |
| rx_err | input | 3 | Error flags of the offered character (bit 0 parity, bit 1 framing, bit 2 break) |
| rbr_rd | input | 1 | Bus pops the head character |
| stat_rd | input | 1 | Bus reads the status word |
| thr_wr | input | 1 | Bus writes the transmit holding register |
| tx_load | input | 1 | Shifter takes the holding register contents |
| tx_busy | input | 1 | Transmit shift register holds data |
| rbr_data | output | DATA_W | Head character, 0 when empty |
| lsr | output | 8 | Line status word |

## Verification
The embedded properties assume several things about the inputs. `rbr_rd` and `stat_rd` are single-cycle bus strobes. `rx_err` matters only while `rx_valid` is high. `tx_load` is raised only while the holding register is full. The directed stimulus drives every strobe for exactly one cycle, between falling edges. It pulses `tx_load` only after a holding-register write. It changes `fifo_en` only while no other strobe is active, so the flush cycle never coincides with a push or pop.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
   localparam int ERR_W  = 3;
   localparam int LSR_W  = 8;

   // status word field positions (software decodes these)
   localparam int ST_DR   = 0;
   localparam int ST_OVR  = 1;
   localparam int ST_PAR  = 2;
   localparam int ST_FRM  = 3;
   localparam int ST_BRK  = 4;
   localparam int ST_THRE = 5;
   localparam int ST_TEMT = 6;
   localparam int ST_FERR = 7;

   // error flag positions within rx_err
   localparam int EF_PAR = 0;
   localparam int EF_FRM = 1;
   localparam int EF_BRK = 2;
endpackage

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
   import uart_lsr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              single,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic [ERR_W-1:0]  push_err,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic [ERR_W-1:0]  head_err,
   output logic              full,
   output logic              empty,
   output logic              head_load,
   output logic [ERR_W-1:0]  head_load_err,
   output logic              bad_zero_next
);
   logic [DATA_W-1:0] mem_d [DEPTH];
   logic [ERR_W-1:0]  mem_e [DEPTH];
   logic [PW-1:0]     wptr, rptr, nxt_rptr;
   logic [CW-1:0]     count, count_nxt, bad_cnt, bad_nxt;
   logic              do_push, do_pop;

   initial begin : elab_chk
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 2");
      assert (DATA_W >= 5 && DATA_W <= 9)
         else $error("DATA_W out of range");
   end

   assign empty    = (count == '0);
   assign full     = single ? !empty : (count == CW'(DEPTH));
   assign do_push  = push && !flush;
   assign do_pop   = pop && !empty && !flush;
   assign nxt_rptr = rptr + PW'(1);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (do_push && wptr == PW'(i)) begin
            mem_d[i] <= push_data;
            mem_e[i] <= push_err;
         end
      end
   end

   assign count_nxt = flush ? '0 : (count + CW'(do_push) - CW'(do_pop));
   assign bad_nxt   = flush ? '0 :
                      (bad_cnt + CW'(do_push && (|push_err)) - CW'(do_pop && (|head_err)));
   assign bad_zero_next = (bad_nxt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         count   <= '0;
         bad_cnt <= '0;
      end else begin
         count   <= count_nxt;
         bad_cnt <= bad_nxt;
         if (flush) begin
            wptr <= '0;
            rptr <= '0;
         end else begin
            if (do_push) wptr <= wptr + PW'(1);
            if (do_pop)  rptr <= nxt_rptr;
         end
      end
   end

   assign head_data = empty ? '0 : mem_d[rptr];
   assign head_err  = empty ? '0 : mem_e[rptr];

   // which character becomes head at the next edge, and its flags
   always_comb begin
      head_load     = 1'b0;
      head_load_err = '0;
      if (do_pop && count > CW'(1)) begin
         head_load     = 1'b1;
         head_load_err = mem_e[nxt_rptr];
      end else if (do_push && (empty || do_pop)) begin
         head_load     = 1'b1;
         head_load_err = push_err;
      end
   end

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));
   p_single_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (single && !flush) |-> (count <= CW'(1)));
   p_bad_le_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bad_cnt <= count);
   p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
endmodule

// File: rtl/lsr_err_track.sv
module lsr_err_track
   import uart_lsr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             stat_rd,
   input  logic             head_load,
   input  logic [ERR_W-1:0] head_load_err,
   input  logic             ovr_evt,
   input  logic             push_bad,
   input  logic             bad_zero_next,
   output logic [ERR_W-1:0] flags,
   output logic             ovr,
   output logic             fifo_bad
);
   logic [ERR_W-1:0] flg_q;

   // one sticky flop per flag; a new head error beats a status read
   for (genvar b = 0; b < ERR_W; b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          flg_q[b] <= 1'b0;
         else if (head_load && head_load_err[b]) flg_q[b] <= 1'b1;
         else if (stat_rd)                    flg_q[b] <= 1'b0;
      end
   end
   assign flags = flg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr <= 1'b0;
      else if (ovr_evt) ovr <= 1'b1;
      else if (stat_rd) ovr <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          fifo_bad <= 1'b0;
      else if (!fifo_en)                   fifo_bad <= 1'b0;
      else if (push_bad)                   fifo_bad <= 1'b1;
      else if (stat_rd && bad_zero_next)   fifo_bad <= 1'b0;
   end

   p_rdclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !head_load && !ovr_evt) |=> (flags == '0 && !ovr));
   p_head_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
      head_load |=> ((flags & $past(head_load_err)) == $past(head_load_err)));
   p_ovr_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> ovr);
   p_sum_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && push_bad) |=> fifo_bad);
   p_sum_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> !fifo_bad);
   p_sum_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && !bad_zero_next) |=> fifo_bad || !$past(fifo_bad));
endmodule

// File: rtl/lsr_tx_status.sv
module lsr_tx_status (
   input  logic clk,
   input  logic rst_n,
   input  logic thr_wr,
   input  logic tx_load,
   input  logic tx_busy,
   output logic thre,
   output logic temt
);
   logic hold_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_full <= 1'b0;
      else if (thr_wr)  hold_full <= 1'b1;
      else if (tx_load) hold_full <= 1'b0;
   end

   assign thre = !hold_full;
   assign temt = !hold_full && !tx_busy;

   p_wr_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !thre);
   p_load_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && !thr_wr) |=> thre);
   p_busy_temt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> !temt);
endmodule

// File: rtl/uart_lsr_rxq.sv
module uart_lsr_rxq
   import uart_lsr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [2:0]        rx_err,
   input  logic              rbr_rd,
   input  logic              stat_rd,
   input  logic              thr_wr,
   input  logic              tx_load,
   input  logic              tx_busy,
   output logic [DATA_W-1:0] rbr_data,
   output logic [7:0]        lsr
);
   logic             mode_q, flush;
   logic             q_full, q_empty, head_load, bad_zero_next;
   logic [ERR_W-1:0] head_err, head_load_err, flags;
   logic             pop_fire, accept, ovr_evt, push_bad;
   logic             ovr, fifo_bad, thre, temt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= fifo_en;
   end
   assign flush = (fifo_en != mode_q);

   assign pop_fire = rbr_rd && !q_empty;
   assign accept   = rx_valid && !flush && (!q_full || pop_fire);
   assign ovr_evt  = rx_valid && !flush && !accept;
   assign push_bad = accept && (|rx_err);

   lsr_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush         (flush),
      .single        (!fifo_en),
      .push          (accept),
      .push_data     (rx_data),
      .push_err      (rx_err),
      .pop           (rbr_rd),
      .head_data     (rbr_data),
      .head_err      (head_err),
      .full          (q_full),
      .empty         (q_empty),
      .head_load     (head_load),
      .head_load_err (head_load_err),
      .bad_zero_next (bad_zero_next)
   );

   lsr_err_track u_err (
      .clk           (clk),
      .rst_n         (rst_n),
      .fifo_en       (fifo_en),
      .stat_rd       (stat_rd),
      .head_load     (head_load),
      .head_load_err (head_load_err),
      .ovr_evt       (ovr_evt),
      .push_bad      (push_bad),
      .bad_zero_next (bad_zero_next),
      .flags         (flags),
      .ovr           (ovr),
      .fifo_bad      (fifo_bad)
   );

   lsr_tx_status u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .thr_wr  (thr_wr),
      .tx_load (tx_load),
      .tx_busy (tx_busy),
      .thre    (thre),
      .temt    (temt)
   );

   always_comb begin
      lsr          = '0;
      lsr[ST_DR]   = !q_empty;
      lsr[ST_OVR]  = ovr;
      lsr[ST_PAR]  = flags[EF_PAR];
      lsr[ST_FRM]  = flags[EF_FRM];
      lsr[ST_BRK]  = flags[EF_BRK];
      lsr[ST_THRE] = thre;
      lsr[ST_TEMT] = temt;
      lsr[ST_FERR] = fifo_bad;
   end

   p_empty_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !lsr[ST_DR] |-> (rbr_data == '0));
   p_head_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (head_load && !flush) |=> ((flags & head_err) == head_err));
endmodule

// File: tb/uart_lsr_rxq_test.sv
module uart_lsr_rxq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b1;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic [2:0] rx_err = '0;
   logic       rbr_rd = 1'b0, stat_rd = 1'b0;
   logic       thr_wr = 1'b0, tx_load = 1'b0, tx_busy = 1'b0;
   logic [7:0] rbr_data, lsr;
   int         nvec = 0, nbad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   uart_lsr_rxq uut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_err(rx_err), .rbr_rd(rbr_rd), .stat_rd(stat_rd),
      .thr_wr(thr_wr), .tx_load(tx_load), .tx_busy(tx_busy),
      .rbr_data(rbr_data), .lsr(lsr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic push_char(input logic [7:0] d, input logic [2:0] e);
      rx_valid = 1'b1; rx_data = d; rx_err = e;
      cyc();
      rx_valid = 1'b0; rx_err = '0;
   endtask

   task automatic pop_char();
      rbr_rd = 1'b1; cyc(); rbr_rd = 1'b0;
   endtask

   task automatic read_stat();
      stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
   endtask

   task automatic set_mode(input logic m);
      fifo_en = m; cyc(); cyc();
   endtask

   task automatic t_reset();
      chk("R8 R9 reset status", lsr, 8'h60);
      chk("R1 reset rbr", rbr_data, 8'h00);
   endtask

   task automatic t_order();
      push_char(8'hA1, 3'b000);
      chk("R1 ready after push", lsr[0], 1);
      chk("R1 head data", rbr_data, 8'hA1);
      push_char(8'hB2, 3'b001);
      chk("R6 summary on errored push", lsr[7], 1);
      chk("R3 clean head no parity", lsr[4:2], 3'b000);
      push_char(8'hC3, 3'b000);
      read_stat();
      chk("R7 summary kept, errored char queued", lsr[7], 1);
      pop_char();
      chk("R1 order second", rbr_data, 8'hB2);
      chk("R3 parity shown at head", lsr[4:2], 3'b001);
      read_stat();
      chk("R4 parity cleared by read", lsr[2], 0);
      chk("R4 char kept after read", rbr_data, 8'hB2);
      chk("R7 summary kept while B2 queued", lsr[7], 1);
      pop_char();
      chk("R1 order third", rbr_data, 8'hC3);
      chk("R7 summary not cleared by pop", lsr[7], 1);
      read_stat();
      chk("R7 summary cleared by read", lsr[7], 0);
      pop_char();
      chk("R1 empty ready", lsr[0], 0);
      chk("R1 empty rbr", rbr_data, 8'h00);
   endtask

   task automatic t_overrun();
      for (int i = 0; i < 16; i++) push_char(8'h10 + 8'(i), 3'b000);
      chk("R2 no overrun at capacity", lsr[1], 0);
      push_char(8'hEE, 3'b000);
      chk("R2 overrun set", lsr[1], 1);
      read_stat();
      chk("R4 overrun cleared", lsr[1], 0);
      for (int i = 0; i < 16; i++) begin
         chk("R2 stored data", rbr_data, 8'h10 + 8'(i));
         pop_char();
      end
      chk("R2 dropped char absent", lsr[0], 0);
   endtask

   task automatic t_priority();
      push_char(8'h55, 3'b000);
      push_char(8'h66, 3'b010);
      rbr_rd = 1'b1; stat_rd = 1'b1;
      cyc();
      rbr_rd = 1'b0; stat_rd = 1'b0;
      chk("R5 framing survives same-cycle read", lsr[3], 1);
      chk("R5 new head", rbr_data, 8'h66);
      pop_char();
      read_stat();
      chk("R4 framing cleared", lsr[3], 0);
      chk("R7 summary cleared when none left", lsr[7], 0);
      for (int i = 0; i < 16; i++) push_char(8'h20 + 8'(i), 3'b000);
      rx_valid = 1'b1; rx_data = 8'hFF; stat_rd = 1'b1;
      cyc();
      rx_valid = 1'b0; stat_rd = 1'b0;
      chk("R5 overrun survives same-cycle read", lsr[1], 1);
      read_stat();
   endtask

   task automatic t_nofifo();
      chk("R10 precondition full", lsr[0], 1);
      set_mode(1'b0);
      chk("R10 flushed on mode change", lsr[0], 0);
      push_char(8'h77, 3'b100);
      chk("R3 break on reception", lsr[4], 1);
      chk("R7 summary held 0 without fifo", lsr[7], 0);
      push_char(8'h88, 3'b000);
      chk("R2 single slot overrun", lsr[1], 1);
      chk("R2 first char kept", rbr_data, 8'h77);
      pop_char();
      chk("R1 single slot emptied", lsr[0], 0);
      read_stat();
      set_mode(1'b1);
   endtask

   task automatic t_tx();
      thr_wr = 1'b1; cyc(); thr_wr = 1'b0;
      chk("R8 holding full after write", lsr[5], 0);
      chk("R9 tx not empty", lsr[6], 0);
      tx_load = 1'b1; tx_busy = 1'b1; cyc(); tx_load = 1'b0;
      chk("R8 holding empty after load", lsr[5], 1);
      chk("R9 shifter busy", lsr[6], 0);
      tx_busy = 1'b0; cyc();
      chk("R9 tx empty", lsr[6], 1);
      thr_wr = 1'b1; cyc();
      tx_load = 1'b1; cyc(); thr_wr = 1'b0; tx_load = 1'b0;
      chk("R8 write beats load", lsr[5], 0);
      tx_load = 1'b1; cyc(); tx_load = 1'b0;
      chk("R8 load empties", lsr[5], 1);
   endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc(); cyc();
      t_reset();
      t_order();
      t_overrun();
      t_priority();
      t_nofifo();
      t_tx();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nvec++; nbad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule